// File: doc/BRIEF.md
# Real-Mode Operand Address and Pointer Load Unit

This block takes the addressing-mode fields of a 16-bit real-mode operand specifier, the base and index register values, and up to two displacement bytes. From these it forms the operand offset and picks the default segment. It then performs one of four operations. The address-only operation writes the offset itself into a destination register. The load operation reads one word from memory and writes that word to the register. The two far-pointer loads read two consecutive words. The first word goes to the register, and the second goes to either the data segment or the extra segment.

The operation starts with a one-cycle `start` pulse while the unit is idle. Memory reads use a simple request/ready handshake. All register and segment writes, and the completion pulse, leave the block through registered strobes. The physical read address is the segment value times sixteen plus the offset, kept to 20 bits.

Top module: `ea_ptr_unit`

## Requirements
- R1: With `mode_f` 00 (except `rm_f`=110), the offset is the base/index sum selected by `rm_f`: 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 6 BP, 7 BX. `mode_f` 01 adds `disp_lo` sign-extended to 16 bits. `mode_f` 10 adds the 16-bit displacement {`disp_hi`,`disp_lo`}. All sums wrap modulo 65536.
- R2: With `mode_f`=00 and `rm_f`=110, the offset is {`disp_hi`,`disp_lo`} alone, with no register added, and the data segment is used.
- R3: A BP operand encoded as `mode_f`=01, `rm_f`=110 with `disp_lo`=00H yields offset BP and uses the stack segment.
- R4: Forms with BP as base (`rm_f` 2, 3, and 6 when `mode_f` is not 00) use `ss_val`, and all others use `ds_val`. `mem_addr` = (segment×16 + offset) mod 2^20.
- R5: `op`=0 (address only) asserts `reg_we` in the cycle after `start`, with `wr_data` equal to the offset and `reg_idx`=`dst_sel`. It never raises `mem_req`.
- R6: `op`=1 (load) issues exactly one read. In the cycle after the read completes (`mem_req`&&`mem_rdy` at a clock edge), it asserts `reg_we` with the data read.
- R7: `op`=2 and `op`=3 (far-pointer loads) read at the offset and then at offset+2 (the offset wrapping modulo 65536). The first word is written through `reg_we`. The second word is written through `seg_we`, with `seg_es`=0 for op 2 and `seg_es`=1 for op 3.
- R8: `mode_f`=11 is illegal for every operation. `err` pulses for one cycle after `start`, and no read, register or segment write, or `done` follows.
- R9: `done` pulses for exactly one cycle, in the cycle right after the last write of an operation.
- R10: While `mem_req` is high and `mem_rdy` is low, `mem_addr` holds steady. `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | 0 address, 1 load, 2 far load to DS, 3 far load to ES |
| mode_f | input | 2 | Addressing mode field |
| rm_f | input | 3 | Register/memory field |
| dst_sel | input | 3 | Destination register index |
| bx_val | input | 16 | BX value |
| bp_val | input | 16 | BP value |
| si_val | input | 16 | SI value |
| di_val | input | 16 | DI value |
| ds_val | input | 16 | Data segment value |
| ss_val | input | 16 | Stack segment value |
| disp_lo | input | 8 | Low displacement byte |
| disp_hi | input | 8 | High displacement byte |
| mem_rdy | input | 1 | Read data valid, completes a request |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Read request |
| mem_addr | output | 20 | Physical read address |
| reg_we | output | 1 | Register write strobe |
| reg_idx | output | 3 | Register written |
| seg_we | output | 1 | Segment write strobe |
| seg_es | output | 1 | Segment written: 0 DS, 1 ES |
| wr_data | output | 16 | Data for either write strobe |
| done | output | 1 | Operation complete |
| err | output | 1 | Illegal mode rejected |

## Verification
The hardest case to reach is the far-pointer second read when the offset sits at FFFEH or FFFFH. To reach it, the offset must wrap inside the segment while the physical address still carries the segment base. The handshake must also stall at both reads. Directed cases set BX+SI and the direct displacement to those edge offsets. Random stimulus withholds `mem_rdy` on about a third of the cycles, so waits happen at both the first and the second read.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int WORD_W   = 16;
    localparam int SEG_SH   = 4;
    localparam int PHYS_W   = WORD_W + SEG_SH;
    localparam int REG_IW   = 3;
    localparam int PTR_STEP = 2;

    typedef enum logic [1:0] {
        OP_ADDR = 2'd0,
        OP_LOAD = 2'd1,
        OP_FAR_DS = 2'd2,
        OP_FAR_ES = 2'd3
    } ea_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD1  = 2'd1,
        ST_RD2  = 2'd2,
        ST_FIN  = 2'd3
    } ea_state_e;

    typedef struct packed {
        ea_state_e           state;
        ea_op_e              op;
        logic [WORD_W-1:0]   off;
        logic [WORD_W-1:0]   seg;
        logic [REG_IW-1:0]   dst;
        logic                reg_we;
        logic                seg_we;
        logic                seg_es;
        logic [WORD_W-1:0]   wdata;
        logic                done;
        logic                err;
    } ea_regs_t;
endpackage

// File: rtl/ea_offset_calc.sv
module ea_offset_calc
    import ea_pkg::*;
(
    input  logic [1:0]        mode_f,
    input  logic [2:0]        rm_f,
    input  logic [WORD_W-1:0] bx_val,
    input  logic [WORD_W-1:0] bp_val,
    input  logic [WORD_W-1:0] si_val,
    input  logic [WORD_W-1:0] di_val,
    input  logic [7:0]        disp_lo,
    input  logic [7:0]        disp_hi,
    output logic [WORD_W-1:0] offset,
    output logic              use_stack,
    output logic              illegal
);
    logic              direct;
    logic [WORD_W-1:0] base_sum;
    logic [WORD_W-1:0] disp;

    assign direct  = (mode_f == 2'b00) && (rm_f == 3'd6);
    assign illegal = (mode_f == 2'b11);

    always_comb begin
        unique case (rm_f)
            3'd0: base_sum = bx_val + si_val;
            3'd1: base_sum = bx_val + di_val;
            3'd2: base_sum = bp_val + si_val;
            3'd3: base_sum = bp_val + di_val;
            3'd4: base_sum = si_val;
            3'd5: base_sum = di_val;
            3'd6: base_sum = bp_val;
            default: base_sum = bx_val;
        endcase
    end

    always_comb begin
        unique case (mode_f)
            2'b01:   disp = {{(WORD_W-8){disp_lo[7]}}, disp_lo};
            2'b10:   disp = {disp_hi, disp_lo};
            default: disp = '0;
        endcase
    end

    assign offset    = direct ? {disp_hi, disp_lo} : (base_sum + disp);
    assign use_stack = (rm_f == 3'd2) || (rm_f == 3'd3) || ((rm_f == 3'd6) && !direct);
endmodule

// File: rtl/ea_seq.sv
module ea_seq
    import ea_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              illegal,
    input  logic [WORD_W-1:0] offset,
    input  logic [WORD_W-1:0] seg_base,
    input  logic [REG_IW-1:0] dst_sel,
    input  logic              mem_rdy,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic [PHYS_W-1:0] mem_addr,
    output logic              reg_we,
    output logic [REG_IW-1:0] reg_idx,
    output logic              seg_we,
    output logic              seg_es,
    output logic [WORD_W-1:0] wr_data,
    output logic              done,
    output logic              err
);
    ea_regs_t r_d, r_q;
    logic [WORD_W-1:0] eff_off;

    always_comb begin
        r_d        = r_q;
        r_d.reg_we = 1'b0;
        r_d.seg_we = 1'b0;
        r_d.done   = 1'b0;
        r_d.err    = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (illegal) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.op     = ea_op_e'(op);
                        r_d.off    = offset;
                        r_d.seg    = seg_base;
                        r_d.dst    = dst_sel;
                        r_d.seg_es = (ea_op_e'(op) == OP_FAR_ES);
                        if (ea_op_e'(op) == OP_ADDR) begin
                            r_d.reg_we = 1'b1;
                            r_d.wdata  = offset;
                            r_d.state  = ST_FIN;
                        end else begin
                            r_d.state  = ST_RD1;
                        end
                    end
                end
            end
            ST_RD1: begin
                if (mem_rdy) begin
                    r_d.reg_we = 1'b1;
                    r_d.wdata  = mem_rdata;
                    r_d.state  = (r_q.op == OP_LOAD) ? ST_FIN : ST_RD2;
                end
            end
            ST_RD2: begin
                if (mem_rdy) begin
                    r_d.seg_we = 1'b1;
                    r_d.wdata  = mem_rdata;
                    r_d.state  = ST_FIN;
                end
            end
            default: begin
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign eff_off  = (r_q.state == ST_RD2) ? (r_q.off + WORD_W'(PTR_STEP)) : r_q.off;
    assign mem_addr = {r_q.seg, {SEG_SH{1'b0}}} + {{SEG_SH{1'b0}}, eff_off};
    assign mem_req  = (r_q.state == ST_RD1) || (r_q.state == ST_RD2);
    assign busy     = (r_q.state != ST_IDLE);
    assign reg_we   = r_q.reg_we;
    assign reg_idx  = r_q.dst;
    assign seg_we   = r_q.seg_we;
    assign seg_es   = r_q.seg_es;
    assign wr_data  = r_q.wdata;
    assign done     = r_q.done;
    assign err      = r_q.err;
endmodule

// File: rtl/ea_ptr_unit.sv
module ea_ptr_unit
    import ea_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [1:0]        mode_f,
    input  logic [2:0]        rm_f,
    input  logic [REG_IW-1:0] dst_sel,
    input  logic [WORD_W-1:0] bx_val,
    input  logic [WORD_W-1:0] bp_val,
    input  logic [WORD_W-1:0] si_val,
    input  logic [WORD_W-1:0] di_val,
    input  logic [WORD_W-1:0] ds_val,
    input  logic [WORD_W-1:0] ss_val,
    input  logic [7:0]        disp_lo,
    input  logic [7:0]        disp_hi,
    input  logic              mem_rdy,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic [PHYS_W-1:0] mem_addr,
    output logic              reg_we,
    output logic [REG_IW-1:0] reg_idx,
    output logic              seg_we,
    output logic              seg_es,
    output logic [WORD_W-1:0] wr_data,
    output logic              done,
    output logic              err
);
    logic [WORD_W-1:0] offset;
    logic              use_stack;
    logic              illegal;
    logic [WORD_W-1:0] seg_base;

    ea_offset_calc u_calc (
        .mode_f   (mode_f),
        .rm_f     (rm_f),
        .bx_val   (bx_val),
        .bp_val   (bp_val),
        .si_val   (si_val),
        .di_val   (di_val),
        .disp_lo  (disp_lo),
        .disp_hi  (disp_hi),
        .offset   (offset),
        .use_stack(use_stack),
        .illegal  (illegal)
    );

    assign seg_base = use_stack ? ss_val : ds_val;

    ea_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op       (op),
        .illegal  (illegal),
        .offset   (offset),
        .seg_base (seg_base),
        .dst_sel  (dst_sel),
        .mem_rdy  (mem_rdy),
        .mem_rdata(mem_rdata),
        .busy     (busy),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .reg_we   (reg_we),
        .reg_idx  (reg_idx),
        .seg_we   (seg_we),
        .seg_es   (seg_es),
        .wr_data  (wr_data),
        .done     (done),
        .err      (err)
    );
endmodule

// File: rtl/ea_ptr_unit_chk.sv
module ea_ptr_unit_chk
    import ea_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        op,
    input logic [1:0]        mode_f,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_rdy,
    input logic [PHYS_W-1:0] mem_addr,
    input logic              reg_we,
    input logic              seg_we,
    input logic              done,
    input logic              err
);
    // R5: address-only operation writes next cycle without touching memory
    assert_addr_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op == 2'd0 && mode_f != 2'b11) |=> (reg_we && !mem_req));

    // R8: illegal mode raises err and produces no write
    assert_illegal_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode_f == 2'b11) |=> (err && !reg_we && !seg_we && !mem_req && !busy));

    // R9: done only right after a write
    assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(reg_we) || $past(seg_we)));

    // R9: done never lasts two cycles
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: address held while a read waits
    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr)));

    // R7: register and segment strobes never coincide
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && seg_we));
endmodule

bind ea_ptr_unit ea_ptr_unit_chk chk_i (.*);

// File: tb/ea_ptr_unit_tb_top.sv
module ea_ptr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [1:0]  mode_f = '0;
    logic [2:0]  rm_f = '0;
    logic [2:0]  dst_sel = '0;
    logic [15:0] bx_val = '0, bp_val = '0, si_val = '0, di_val = '0;
    logic [15:0] ds_val = '0, ss_val = '0;
    logic [7:0]  disp_lo = '0, disp_hi = '0;
    logic        mem_rdy = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        busy, mem_req, reg_we, seg_we, seg_es, done, err;
    logic [19:0] mem_addr;
    logic [2:0]  reg_idx;
    logic [15:0] wr_data;

    int checks = 0;
    int fails  = 0;
    int total_cyc = 0;

    always #2.5 clk = ~clk;

    ea_ptr_unit dut_i (.*);

    always @(posedge clk) begin
        total_cyc++;
        if (total_cyc == 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [15:0] mem_fn(input logic [19:0] a);
        return a[15:0] ^ {a[19:16], a[19:16], 8'h5A};
    endfunction

    function automatic logic [15:0] exp_off(input logic [1:0] m, input logic [2:0] r,
        input logic [15:0] bx, bp, si, di, input logic [7:0] lo, hi);
        logic [15:0] b, d;
        case (r)
            3'd0: b = bx + si;  3'd1: b = bx + di;
            3'd2: b = bp + si;  3'd3: b = bp + di;
            3'd4: b = si;       3'd5: b = di;
            3'd6: b = bp;       default: b = bx;
        endcase
        if (m == 2'b00 && r == 3'd6) return {hi, lo};
        d = (m == 2'b01) ? {{8{lo[7]}}, lo} : (m == 2'b10) ? {hi, lo} : 16'h0;
        return b + d;
    endfunction

    function automatic logic exp_ss(input logic [1:0] m, input logic [2:0] r);
        return (r == 3'd2) || (r == 3'd3) || (r == 3'd6 && m != 2'b00);
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] o, input logic [1:0] m, input logic [2:0] r,
                          input logic hold_start, input string req);
        logic [19:0] raddr [2];
        logic [15:0] rdat [2];
        int nreads = 0, nreg = 0, nseg = 0, ndone = 0, nerr = 0, nreq = 0;
        int reg_cyc = -1, seg_cyc = -1, done_cyc = -1, err_cyc = -1;
        logic [15:0] reg_d = '0, seg_d = '0;
        logic [2:0]  reg_i = '0;
        logic        seg_e = 1'b0;
        logic        prev_wait = 1'b0;
        logic [19:0] prev_addr = '0;
        logic [15:0] off, seg;
        logic        illegal;
        raddr[0] = '0; raddr[1] = '0; rdat[0] = '0; rdat[1] = '0;
        @(negedge clk);
        op = o; mode_f = m; rm_f = r;
        start = 1'b1;
        off = exp_off(m, r, bx_val, bp_val, si_val, di_val, disp_lo, disp_hi);
        seg = exp_ss(m, r) ? ss_val : ds_val;
        illegal = (m == 2'b11);
        for (int c = 1; c <= 40; c++) begin
            @(negedge clk);
            if (!hold_start || done) start = 1'b0;
            if (hold_start && !done) begin
                op = ~o; mode_f = 2'b10; rm_f = ~r;
            end
            if (prev_wait) chk(mem_req && mem_addr == prev_addr, "R10 hold", mem_addr, prev_addr);
            if (reg_we) begin nreg++; reg_cyc = c; reg_d = wr_data; reg_i = reg_idx; end
            if (seg_we) begin nseg++; seg_cyc = c; seg_d = wr_data; seg_e = seg_es; end
            if (done) begin ndone++; if (done_cyc < 0) done_cyc = c; end
            if (err) begin nerr++; err_cyc = c; end
            mem_rdy = 1'b0;
            prev_wait = 1'b0;
            if (mem_req) begin
                nreq++;
                mem_rdata = mem_fn(mem_addr);
                if (($urandom % 3) != 0 && nreads < 2) begin
                    mem_rdy = 1'b1;
                    raddr[nreads] = mem_addr;
                    rdat[nreads] = mem_fn(mem_addr);
                    nreads++;
                end else begin
                    prev_wait = 1'b1;
                    prev_addr = mem_addr;
                end
            end
            if (c > 3 && (done_cyc > 0 || err_cyc > 0) && c >= (done_cyc > err_cyc ? done_cyc : err_cyc) + 2) break;
        end
        start = 1'b0;
        mem_rdy = 1'b0;
        if (illegal) begin
            chk(nerr == 1 && err_cyc == 1, {req, " R8 err"}, err_cyc, 1);
            chk(nreg == 0 && nseg == 0 && ndone == 0 && nreq == 0, {req, " R8 nowrite"}, nreg + nseg + ndone + nreq, 0);
            return;
        end
        chk(nerr == 0, {req, " R8 noerr"}, nerr, 0);
        chk(ndone == 1, {req, " R9 one done"}, ndone, 1);
        chk(nreg == 1 && reg_i == dst_sel, {req, " R6 reg write idx"}, reg_i, dst_sel);
        case (o)
            2'd0: begin
                chk(nreq == 0, {req, " R5 no read"}, nreq, 0);
                chk(reg_cyc == 1 && reg_d == off, {req, " R5 R1 offset"}, reg_d, off);
                chk(done_cyc == reg_cyc + 1, {req, " R9 timing"}, done_cyc, reg_cyc + 1);
            end
            2'd1: begin
                chk(nreads == 1 && raddr[0] == phys(seg, off), {req, " R4 R6 addr"}, raddr[0], phys(seg, off));
                chk(reg_d == rdat[0], {req, " R6 data"}, reg_d, rdat[0]);
                chk(nseg == 0, {req, " R6 no seg"}, nseg, 0);
                chk(done_cyc == reg_cyc + 1, {req, " R9 timing"}, done_cyc, reg_cyc + 1);
            end
            default: begin
                chk(nreads == 2 && raddr[0] == phys(seg, off), {req, " R7 addr1"}, raddr[0], phys(seg, off));
                chk(raddr[1] == phys(seg, off + 16'd2), {req, " R7 addr2"}, raddr[1], phys(seg, off + 16'd2));
                chk(reg_d == rdat[0], {req, " R7 reg word"}, reg_d, rdat[0]);
                chk(nseg == 1 && seg_d == rdat[1], {req, " R7 seg word"}, seg_d, rdat[1]);
                chk(seg_e == (o == 2'd3), {req, " R7 seg select"}, seg_e, o == 2'd3);
                chk(seg_cyc > reg_cyc && done_cyc == seg_cyc + 1, {req, " R9 timing"}, done_cyc, seg_cyc + 1);
            end
        endcase
    endtask

    initial begin
        void'($urandom(32'h1A2B3C));
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !reg_we && !seg_we && !done && !err, "reset R9", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        ds_val = 16'h1234; ss_val = 16'hF000;
        bx_val = 16'h0100; bp_val = 16'h2000; si_val = 16'h0010; di_val = 16'h0020;
        dst_sel = 3'd5;
        // R2: direct address, DS
        disp_lo = 8'h00; disp_hi = 8'h10;
        run_op(2'd0, 2'b00, 3'd6, 1'b0, "R2 direct lea");
        run_op(2'd1, 2'b00, 3'd6, 1'b0, "R2 direct load");
        // R3: BP with zero 8-bit displacement, SS
        disp_lo = 8'h00; disp_hi = 8'h77;
        run_op(2'd0, 2'b01, 3'd6, 1'b0, "R3 bp lea");
        run_op(2'd1, 2'b01, 3'd6, 1'b0, "R3 R4 bp load");
        // R1: negative 8-bit displacement
        disp_lo = 8'hF0;
        run_op(2'd0, 2'b01, 3'd0, 1'b0, "R1 negdisp");
        // R1 wrap and R7 far pointer across the segment end
        bx_val = 16'hFFFF; si_val = 16'h0000;
        run_op(2'd2, 2'b00, 3'd0, 1'b0, "R7 wrap lds");
        disp_lo = 8'hFE; disp_hi = 8'hFF; ds_val = 16'hFFFF;
        run_op(2'd3, 2'b00, 3'd6, 1'b0, "R7 R4 wrap les");
        // R8 illegal mode for each op
        for (int k = 0; k < 4; k++) run_op(k[1:0], 2'b11, 3'd3, 1'b0, "R8 illegal");
        // R10 start held while busy
        run_op(2'd2, 2'b10, 3'd2, 1'b1, "R10 busy start");
        run_op(2'd0, 2'b10, 3'd7, 1'b1, "R10 busy lea");
        // random mix
        for (int n = 0; n < 150; n++) begin
            bx_val = 16'($urandom); bp_val = 16'($urandom);
            si_val = 16'($urandom); di_val = 16'($urandom);
            ds_val = 16'($urandom); ss_val = 16'($urandom);
            disp_lo = 8'($urandom); disp_hi = 8'($urandom);
            dst_sel = 3'($urandom);
            run_op(2'($urandom), 2'($urandom % 3), 3'($urandom), 1'b0, "R1 R4 random");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule